// File: doc/BRIEF.md
# Two-wire bus connection sequencer

This controller decides when the upstream and downstream halves of a buffered two-wire (I2C/SMBus) bus may be joined. It watches sampled SDA and SCL levels on both halves, recognises stop conditions and stretches of bus inactivity, and closes the link only at a transaction boundary, so a card inserted into a live system never joins mid-transfer. Analog functions (the pass device, precharge drivers, rise-time boosters) sit outside; this block only produces the flags that switch them.

Power-good gates everything: while it is low the block holds the halves apart with precharge requested. After power is good and the enable input is high, the link closes when both halves are idle, or when one half has just shown a stop while the other is idle. An external stuck-bus timer reports a timeout with a one-cycle pulse; the block then opens the link, allows recovery clocking while enable is high, and either waits for the downstream lines to be released or closes immediately on a fresh enable rising edge.

Top module: `twb_conn_seq`

## Requirements
- R1: While `pwr_good` is low, `connect` is 0 and `precharge_on` is 1 from the next clock on, whatever the bus lines and `enable` do.
- R2: With power good and enable high, `connect` rises only when both halves are idle, or one half shows a stop while the other is idle; two simultaneous stops with neither half idle do not join.
- R3: A half is idle once its SDA and SCL have both been high for IDLE_CYC consecutive synchronised samples (CLK_KHZ*IDLE_US/1000); any low on either line restarts the count. The link closes on the third clock after the count completes (inputs pass two flops, then the state register).
- R4: `precharge_on` is 1 after reset, clears on the first connection, and is set again only by `pwr_good` going low.
- R5: With `enable` low the link is open, `ready_pd` is 1 and `clk_recov_ok` is 0.
- R6: `ready_pd` is 0 only while `connect` is 1 and synchronised enable is high.
- R7: A stop is a rising SDA while SCL is high, after two-flop synchronisation; a rising SDA while SCL is low is not a stop.
- R8: `accel_en` is 1 only while connected and `recov_active` was 0 on the previous clock.
- R9: A `stuck_tmo` pulse while waiting or connected opens the link on the next clock; in that fault state `clk_recov_ok` equals synchronised enable.
- R10: In the fault state a rising edge on `enable` closes the link on the third clock after the edge is applied, even with the downstream lines still low.
- R11: In the fault state, once downstream SDA and SCL are both high the block returns to waiting and joins again only under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above lockout threshold (synchronous) |
| enable | input | 1 | Connection enable (asynchronous, synchronised inside) |
| up_sda | input | 1 | Upstream SDA level |
| up_scl | input | 1 | Upstream SCL level |
| dn_sda | input | 1 | Downstream SDA level |
| dn_scl | input | 1 | Downstream SCL level |
| stuck_tmo | input | 1 | One-cycle pulse from the stuck-bus timer |
| recov_active | input | 1 | Recovery clocking in progress |
| connect | output | 1 | Join the two halves |
| precharge_on | output | 1 | Keep line precharge active |
| accel_en | output | 1 | Rise-time accelerators allowed |
| ready_pd | output | 1 | Pull the active-low ready line down (1 = not ready) |
| clk_recov_ok | output | 1 | Recovery clocking permitted |

## Verification
A wrong state register shows at once on `connect` and `ready_pd`, since both decode it in the same cycle; a state stuck in the fault or waiting state shows as a missing join three clocks after a stop or an enable edge. A broken idle counter shows as a join one cycle early or late relative to IDLE_CYC, which the bench samples exactly. A precharge latch that misbehaves shows as `precharge_on` high while connected or returning without a power-good drop.

// File: rtl/twb_seq_pkg.sv
package twb_seq_pkg;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_JOIN  = 2'd2,
    ST_FAULT = 2'd3
  } seq_st_t;

  // Idle window in clock cycles from clock rate (kHz) and time (us)
  function automatic int unsigned idle_cycles(int unsigned clk_khz, int unsigned idle_us);
    return (clk_khz * idle_us) / 1000;
  endfunction

  // Join rule: both idle, or a stop on one side with the other idle
  function automatic logic join_rule(logic a_idle, logic a_stop, logic b_idle, logic b_stop);
    return (a_idle && b_idle) || (a_stop && b_idle) || (b_stop && a_idle);
  endfunction

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/twb_seg_mon.sv
module twb_seg_mon #(
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic stop_seen,
  output logic idle,
  output logic lines_high
);
  localparam int unsigned CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYC);

  logic          sda_d;
  logic [CW-1:0] cnt;

  assign lines_high = sda_s && scl_s;
  assign stop_seen  = sda_s && !sda_d && scl_s;
  assign idle       = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      cnt   <= '0;
    end else begin
      sda_d <= sda_s;
      if (!lines_high)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twb_conn_fsm.sv
module twb_conn_fsm
  import twb_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic en_s,
  input  logic stuck_tmo,
  input  logic recov_active,
  input  logic up_stop,
  input  logic up_idle,
  input  logic dn_stop,
  input  logic dn_idle,
  input  logic dn_high,
  output logic connect,
  output logic precharge_on,
  output logic accel_en,
  output logic ready_pd,
  output logic clk_recov_ok,
  output logic join_ok,
  output logic force_join
);
  seq_st_t st, nxt;
  logic    en_d;
  logic    en_rise;

  assign en_rise    = en_s && !en_d;
  assign join_ok    = join_rule(up_idle, up_stop, dn_idle, dn_stop);
  assign force_join = (st == ST_FAULT) && en_rise;

  always_comb begin
    nxt = st;
    if (!pwr_good) begin
      nxt = ST_LOCK;
    end else begin
      unique case (st)
        ST_LOCK:  nxt = ST_WAIT;
        ST_WAIT:  if (stuck_tmo) nxt = ST_FAULT;
                  else if (en_s && join_ok) nxt = ST_JOIN;
        ST_JOIN:  if (stuck_tmo) nxt = ST_FAULT;
                  else if (!en_s) nxt = ST_WAIT;
        ST_FAULT: if (force_join) nxt = ST_JOIN;
                  else if (dn_high) nxt = ST_WAIT;
        default:  nxt = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_LOCK;
      en_d         <= 1'b0;
      precharge_on <= 1'b1;
      accel_en     <= 1'b0;
    end else begin
      st       <= nxt;
      en_d     <= en_s;
      accel_en <= (nxt == ST_JOIN) && !recov_active;
      if (!pwr_good)
        precharge_on <= 1'b1;
      else if (nxt == ST_JOIN)
        precharge_on <= 1'b0;
    end
  end

  assign connect      = (st == ST_JOIN);
  assign ready_pd     = !((st == ST_JOIN) && en_s);
  assign clk_recov_ok = (st == ST_FAULT) && en_s;
endmodule

// File: rtl/twb_conn_seq.sv
module twb_conn_seq
  import twb_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned IDLE_US = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic enable,
  input  logic up_sda,
  input  logic up_scl,
  input  logic dn_sda,
  input  logic dn_scl,
  input  logic stuck_tmo,
  input  logic recov_active,
  output logic connect,
  output logic precharge_on,
  output logic accel_en,
  output logic ready_pd,
  output logic clk_recov_ok
);
  localparam int unsigned IDLE_CYC = idle_cycles(CLK_KHZ, IDLE_US);
  localparam int unsigned NSEG = 2;

  logic [4:0]      sync_q;
  logic            en_s;
  logic [NSEG-1:0] seg_sda, seg_scl, seg_stop, seg_idle, seg_high;
  logic            join_ok, force_join;

  twb_sync #(.W(5), .RST_VAL(5'b01111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({enable, dn_scl, dn_sda, up_scl, up_sda}),
    .q     (sync_q)
  );

  assign en_s    = sync_q[4];
  assign seg_sda = {sync_q[2], sync_q[0]};
  assign seg_scl = {sync_q[3], sync_q[1]};

  // segment 0 = upstream, segment 1 = downstream
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    twb_seg_mon #(.IDLE_CYC(IDLE_CYC)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (seg_sda[g]),
      .scl_s      (seg_scl[g]),
      .stop_seen  (seg_stop[g]),
      .idle       (seg_idle[g]),
      .lines_high (seg_high[g])
    );
  end

  twb_conn_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .en_s         (en_s),
    .stuck_tmo    (stuck_tmo),
    .recov_active (recov_active),
    .up_stop      (seg_stop[0]),
    .up_idle      (seg_idle[0]),
    .dn_stop      (seg_stop[1]),
    .dn_idle      (seg_idle[1]),
    .dn_high      (seg_high[1]),
    .connect      (connect),
    .precharge_on (precharge_on),
    .accel_en     (accel_en),
    .ready_pd     (ready_pd),
    .clk_recov_ok (clk_recov_ok),
    .join_ok      (join_ok),
    .force_join   (force_join)
  );
endmodule

// File: rtl/twb_conn_seq_chk.sv
module twb_conn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic stuck_tmo,
  input logic recov_active,
  input logic connect,
  input logic precharge_on,
  input logic accel_en,
  input logic ready_pd,
  input logic clk_recov_ok,
  input logic en_s,
  input logic join_ok,
  input logic force_join
);
  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !connect && precharge_on); // R1
  AST_JOIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connect) |-> $past((join_ok && en_s) || force_join)); // R2
  AST_PRECHARGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> !precharge_on); // R4
  AST_PRECHARGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(precharge_on) |-> $past(!pwr_good)); // R4
  AST_RECOV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_recov_ok |-> !connect && en_s); // R5
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_pd |-> connect && en_s); // R6
  AST_ACCEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    accel_en |-> connect && !$past(recov_active)); // R8
  AST_STUCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_tmo && pwr_good && !force_join |=> !connect); // R9
  AST_FORCE_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    force_join && pwr_good |=> connect); // R10
endmodule

bind twb_conn_seq twb_conn_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_good     (pwr_good),
  .stuck_tmo    (stuck_tmo),
  .recov_active (recov_active),
  .connect      (connect),
  .precharge_on (precharge_on),
  .accel_en     (accel_en),
  .ready_pd     (ready_pd),
  .clk_recov_ok (clk_recov_ok),
  .en_s         (en_s),
  .join_ok      (join_ok),
  .force_join   (force_join)
);

// File: tb/test_twb_conn_seq.sv
`timescale 1ns/1ps
module test_twb_conn_seq;
  localparam int N = 125; // 125 MHz * 1 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, enable = 1'b0;
  logic up_sda = 1'b1, up_scl = 1'b1, dn_sda = 1'b1, dn_scl = 1'b1;
  logic stuck_tmo = 1'b0, recov_active = 1'b0;
  logic connect, precharge_on, accel_en, ready_pd, clk_recov_ok;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twb_conn_seq #(.CLK_KHZ(125000), .IDLE_US(1)) i_twb_conn_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
    .up_sda(up_sda), .up_scl(up_scl), .dn_sda(dn_sda), .dn_scl(dn_scl),
    .stuck_tmo(stuck_tmo), .recov_active(recov_active),
    .connect(connect), .precharge_on(precharge_on), .accel_en(accel_en),
    .ready_pd(ready_pd), .clk_recov_ok(clk_recov_ok)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_join(input int ma, input int mb);
    logic ai, as_, bi, bs;
    ai = (ma == 1); as_ = (ma == 2);
    bi = (mb == 1); bs = (mb == 2);
    if (ai && bi) return 1'b1;
    if ((as_ && bi) || (bs && ai)) return 1'b1;
    return 1'b0;
  endfunction

  // mode: 0 busy, 1 idle, 2 stop pending, 3 data rise with clock low
  task automatic base_lines(input int m, output logic sda, output logic scl);
    case (m)
      0: begin sda = 1'b1; scl = 1'b0; end
      1: begin sda = 1'b1; scl = 1'b1; end
      2: begin sda = 1'b0; scl = 1'b1; end
      default: begin sda = 1'b0; scl = 1'b0; end
    endcase
  endtask

  initial begin
    cyc(1000000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset connect", connect, 1'b0);
    chk("R4 reset precharge", precharge_on, 1'b1);
    chk("R6 reset ready_pd", ready_pd, 1'b1);
    chk("R8 reset accel", accel_en, 1'b0);

    // R1: lockout ignores idle bus and enable
    enable = 1'b1;
    cyc(N + 20);
    chk("R1 lockout connect", connect, 1'b0);
    chk("R1 lockout precharge", precharge_on, 1'b1);

    // R2/R4/R6/R8: power good, both idle -> join
    pwr_good = 1'b1;
    cyc(4);
    chk("R2 idle join", connect, 1'b1);
    chk("R4 precharge cleared", precharge_on, 1'b0);
    chk("R6 ready released", ready_pd, 1'b0);
    chk("R8 accel on", accel_en, 1'b1);

    // R8: recovery clocking forces accelerators off
    recov_active = 1'b1;
    cyc(2);
    chk("R8 accel off in recovery", accel_en, 1'b0);
    chk("R8 still connected", connect, 1'b1);
    recov_active = 1'b0;
    cyc(2);
    chk("R8 accel back", accel_en, 1'b1);

    // R5: enable low opens link
    enable = 1'b0;
    cyc(4);
    chk("R5 disconnect", connect, 1'b0);
    chk("R5 ready_pd", ready_pd, 1'b1);
    chk("R5 recov inhibited", clk_recov_ok, 1'b0);
    chk("R4 precharge stays off", precharge_on, 1'b0);

    // R3: idle restart and exact join cycle
    up_scl = 1'b0;
    cyc(5);
    up_scl = 1'b1;
    enable = 1'b1;
    cyc(N - 20);
    chk("R3 not yet idle", connect, 1'b0);
    up_scl = 1'b0;
    cyc(3);
    up_scl = 1'b1;
    cyc(N + 2);
    chk("R3 restart delays join", connect, 1'b0);
    cyc(1);
    chk("R3 join after full window", connect, 1'b1);

    // R9/R10: fault, recovery permit, forced join
    dn_scl = 1'b0;
    cyc(5);
    chk("R9 join held with busy lines", connect, 1'b1);
    stuck_tmo = 1'b1;
    cyc(1);
    stuck_tmo = 1'b0;
    chk("R9 fault opens link", connect, 1'b0);
    cyc(2);
    chk("R9 recov permitted", clk_recov_ok, 1'b1);
    chk("R9 ready_pd in fault", ready_pd, 1'b1);
    enable = 1'b0;
    cyc(4);
    chk("R5 recov inhibited in fault", clk_recov_ok, 1'b0);
    chk("R10 stays open", connect, 1'b0);
    enable = 1'b1;
    cyc(2);
    chk("R10 not before edge sync", connect, 1'b0);
    cyc(1);
    chk("R10 forced join", connect, 1'b1);

    // R11: fault cleared by downstream release
    stuck_tmo = 1'b1;
    cyc(1);
    stuck_tmo = 1'b0;
    chk("R11 fault again", connect, 1'b0);
    dn_scl = 1'b1;
    cyc(6);
    chk("R11 waits for idle", connect, 1'b0);
    chk("R11 left fault", clk_recov_ok, 1'b0);
    cyc(N + 5);
    chk("R11 rejoin on idle", connect, 1'b1);

    // R4: power loss re-arms precharge
    pwr_good = 1'b0;
    cyc(2);
    chk("R4 precharge on power loss", precharge_on, 1'b1);
    chk("R1 power loss opens", connect, 1'b0);
    pwr_good = 1'b1;
    cyc(3);
    chk("R4 precharge off again", precharge_on, 1'b0);

    // R2/R7: random side conditions
    for (int t = 0; t < 30; t++) begin
      int ma, mb;
      logic e;
      logic a_sda, a_scl, b_sda, b_scl;
      ma = int'($urandom_range(0, 3));
      mb = int'($urandom_range(0, 3));
      if (t == 0) begin ma = 2; mb = 2; end
      if (t == 1) begin ma = 3; mb = 1; end
      if (t == 2) begin ma = 1; mb = 2; end
      enable = 1'b0;
      cyc(4);
      base_lines(ma, a_sda, a_scl);
      base_lines(mb, b_sda, b_scl);
      up_sda = a_sda; up_scl = a_scl; dn_sda = b_sda; dn_scl = b_scl;
      cyc(N + 5);
      enable = 1'b1;
      cyc(4);
      if (ma >= 2) up_sda = 1'b1;
      if (mb >= 2) dn_sda = 1'b1;
      cyc(5);
      e = exp_join(ma, mb);
      chk($sformatf("R2 R7 join modes %0d/%0d", ma, mb), connect, e);
      chk($sformatf("R6 ready modes %0d/%0d", ma, mb), ready_pd, !e);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule